// File: doc/BRIEF.md
# Tick-Driven Match-Compare Timer

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on every cycle in which the slow tick-enable input is high and the run bit is set. It wraps from all-ones to zero. One compare channel raises a sticky status flag on any tick where the live count equals the match register. The flag, gated by an enable bit, drives a level interrupt.

The counter and the match register are treated as if they sat in the slow tick domain. The host never reads the live count or loads the match value directly. It asks for a snapshot, a preset or a match update, then polls a per-operation busy flag until the transfer has landed. Each transfer lands on the third tick after its request, which models a synchroniser into the slow domain. Software that arms an event is expected to keep at least 16 ticks of margin ahead of the counter.

The host port is a plain 32-bit read/write strobe bus. Reads are combinational from the addressed register.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the match register reads 0xFFFFFFFF, the counter is zero and stopped, and the snapshot, status, interrupt-enable, control and access-status registers all read zero, with `irq_o` low.
- R2: With control bit 0 set, the counter adds one on each tick and wraps from 0xFFFFFFFF to 0. With bit 0 clear, ticks leave it unchanged.
- R3: Writing the control register (0x20) with bit 1 set requests a snapshot. Access-status bit 5 stays high until it lands. The count register (0x10) then returns the count held in the landing cycle. Bit 1 reads back as zero, and bit 0 of the same write sets the run state.
- R4: Writing 0x10 stages a preset and raises access-status bit 4. When the preset lands, it replaces the count, overriding that tick's increment.
- R5: Writing 0x00 stages a match value and raises access-status bit 0. Reads of 0x00 return the match value in force, which changes only when the update lands.
- R6: A transfer lands on the third tick after its request cycle, and a tick in the request cycle is not counted. Its busy bit drops in that same cycle. A new request of the same kind while one is busy discards the old one and restarts the wait.
- R7: Status bit 0 at 0x14 becomes 1 on any tick cycle with the run bit set and count equal to match. It then holds until cleared.
- R8: Writing 0x14 clears each status bit written as 1 and leaves the bits written as 0. A match in the same cycle as a clear wins, and the flag stays set.
- R9: `irq_o` is high exactly while status bit 0 and interrupt-enable bit 0 (0x1C) are both 1.
- R10: Reads of any address other than 0x00, 0x10, 0x14, 0x1C, 0x20 and 0x24 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per slow timer tick |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt |

## Verification
A broken transfer counter shows first as an access-status bit that drops a tick early or late. A snapshot read right after the flag clears then returns a count off by one. A corrupted counter or match register shows as a status flag that rises one tick early or late, or never rises. The bench samples status after every tick near the expected match. The set-versus-clear race and the restarted transfer are each forced in a single chosen cycle, so a wrong priority is caught by the read that follows.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  // register byte offsets
  localparam int unsigned OFS_MATCH  = 'h00;
  localparam int unsigned OFS_COUNT  = 'h10;
  localparam int unsigned OFS_STAT   = 'h14;
  localparam int unsigned OFS_IEN    = 'h1C;
  localparam int unsigned OFS_CTRL   = 'h20;
  localparam int unsigned OFS_ACC    = 'h24;

  // transfer slot indices
  localparam int unsigned XF_MATCH  = 0;
  localparam int unsigned XF_PRESET = 1;
  localparam int unsigned XF_SNAP   = 2;
  localparam int unsigned XF_N      = 3;

  // access-status bit positions, decoded by software
  localparam int unsigned ACC_MATCH_BIT  = 0;
  localparam int unsigned ACC_PRESET_BIT = 4;
  localparam int unsigned ACC_SNAP_BIT   = 5;

  localparam int unsigned STAT_W = 4;

  // sticky flag update: set wins over clear
  function automatic logic [STAT_W-1:0] stat_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] set_v,
    input logic [STAT_W-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction
endpackage

// File: rtl/tmt_xfer_slot.sv
module tmt_xfer_slot #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned TW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] tcnt;

  assign done_o = busy_o & tick_i & (tcnt == LAST) & ~req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      tcnt   <= '0;
    end else if (req_i) begin
      busy_o <= 1'b1;
      tcnt   <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
      tcnt   <= '0;
    end else if (busy_o && tick_i) begin
      tcnt   <= tcnt + TW'(1);
    end
  end

  assert_req_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> busy_o);
  assert_done_drops_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  assert_no_land_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !tick_i |=> busy_o);
endmodule

// File: rtl/tmt_counter.sv
module tmt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         step_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] count_step(input logic [W-1:0] c);
    return c + ONE;
  endfunction

  assign step_o = tick_i & run_i & ~load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_o <= '0;
    else if (load_i)  cnt_o <= load_val_i;
    else if (step_o)  cnt_o <= count_step(cnt_o);
  end

  assert_step_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> cnt_o == $past(cnt_o) + ONE);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !(tick_i && run_i) |=> $stable(cnt_o));
  assert_preset_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/tmt_match_stat.sv
module tmt_match_stat
  import tmt_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [W-1:0]      cnt_i,
  input  logic [W-1:0]      match_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              ien_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              hit_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] set_v;

  assign hit_o = tick_i & run_i & (cnt_i == match_i);
  assign set_v = {{(STAT_W-1){1'b0}}, hit_o};
  assign irq_o = stat_o[0] & ien_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= stat_next(stat_o, set_v, clr_i);
  end

  assert_hit_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> stat_o[0]);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[0] && !clr_i[0] |=> stat_o[0]);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[0] && !hit_o |=> !stat_o[0]);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hit_o) || $rose(ien_i));
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned XFER_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ACC   = ADDR_W'(OFS_ACC);

  // write decode events
  logic wr_match, wr_count, wr_stat, wr_ien, wr_ctrl;
  assign wr_match = bus_we && (bus_addr == A_MATCH);
  assign wr_count = bus_we && (bus_addr == A_COUNT);
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign wr_ien   = bus_we && (bus_addr == A_IEN);
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);

  logic            run_q, ien_q;
  logic [DW-1:0]   match_q, pend_match, pend_cnt, snap_q;
  logic [DW-1:0]   cnt;
  logic            step_evt, hit_evt;
  logic [STAT_W-1:0] stat, clr_v;
  logic [XF_N-1:0] xreq, xbusy, xdone;

  assign xreq[XF_MATCH]  = wr_match;
  assign xreq[XF_PRESET] = wr_count;
  assign xreq[XF_SNAP]   = wr_ctrl & bus_wdata[1];

  for (genvar g = 0; g < XF_N; g++) begin : g_slot
    tmt_xfer_slot #(.TICKS(XFER_TICKS)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_en),
      .req_i  (xreq[g]),
      .busy_o (xbusy[g]),
      .done_o (xdone[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      ien_q      <= 1'b0;
      match_q    <= '1;
      pend_match <= '0;
      pend_cnt   <= '0;
      snap_q     <= '0;
    end else begin
      if (wr_ctrl)  run_q      <= bus_wdata[0];
      if (wr_ien)   ien_q      <= bus_wdata[0];
      if (wr_match) pend_match <= bus_wdata;
      if (wr_count) pend_cnt   <= bus_wdata;
      if (xdone[XF_MATCH]) match_q <= pend_match;
      if (xdone[XF_SNAP])  snap_q  <= cnt;
    end
  end

  tmt_counter #(.W(DW)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .run_i      (run_q),
    .load_i     (xdone[XF_PRESET]),
    .load_val_i (pend_cnt),
    .cnt_o      (cnt),
    .step_o     (step_evt)
  );

  assign clr_v = wr_stat ? bus_wdata[STAT_W-1:0] : '0;

  tmt_match_stat #(.W(DW)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_en),
    .run_i   (run_q),
    .cnt_i   (cnt),
    .match_i (match_q),
    .clr_i   (clr_v),
    .ien_i   (ien_q),
    .stat_o  (stat),
    .hit_o   (hit_evt),
    .irq_o   (irq_o)
  );

  logic [DW-1:0] acc_v;
  always_comb begin
    acc_v = '0;
    acc_v[ACC_MATCH_BIT]  = xbusy[XF_MATCH];
    acc_v[ACC_PRESET_BIT] = xbusy[XF_PRESET];
    acc_v[ACC_SNAP_BIT]   = xbusy[XF_SNAP];
  end

  always_comb begin
    unique case (bus_addr)
      A_MATCH: bus_rdata = match_q;
      A_COUNT: bus_rdata = snap_q;
      A_STAT:  bus_rdata = DW'(stat);
      A_IEN:   bus_rdata = DW'(ien_q);
      A_CTRL:  bus_rdata = DW'(run_q);
      A_ACC:   bus_rdata = acc_v;
      default: bus_rdata = '0;
    endcase
  end

  assert_snap_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xdone[XF_SNAP] |=> snap_q == $past(cnt));
  assert_match_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xdone[XF_MATCH] |=> match_q == $past(pend_match));
  assert_match_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xdone[XF_MATCH] |=> $stable(match_q));
  assert_step_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> run_q && tick_en);
endmodule

// File: tb/test_tick_match_timer.sv
module test_tick_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tick_match_timer i_tick_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // entry: kind[76:75] addr[74:69] data[68:37] exp[36:5] irq[4] req[3:0]
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2;
  localparam int NV = 62;
  localparam logic [76:0] VEC [NV] = '{
    {K_RD, 6'h00, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd1},  // R1
    {K_RD, 6'h10, 32'h0, 32'h0,        1'b0, 4'd1},  // R1
    {K_RD, 6'h14, 32'h0, 32'h0,        1'b0, 4'd1},  // R1
    {K_RD, 6'h24, 32'h0, 32'h0,        1'b0, 4'd1},  // R1
    {K_RD, 6'h20, 32'h0, 32'h0,        1'b0, 4'd1},  // R1
    {K_RD, 6'h1C, 32'h0, 32'h0,        1'b0, 4'd1},  // R1
    {K_WR, 6'h10, 32'h100, 32'h0,      1'b0, 4'd4},  // R4 preset
    {K_RD, 6'h24, 32'h0, 32'h10,       1'b0, 4'd4},
    {K_TK, 6'h00, 32'd2, 32'h0,        1'b0, 4'd6},
    {K_RD, 6'h24, 32'h0, 32'h10,       1'b0, 4'd6},  // R6 still busy
    {K_TK, 6'h00, 32'd1, 32'h0,        1'b0, 4'd6},
    {K_RD, 6'h24, 32'h0, 32'h0,        1'b0, 4'd6},  // R6 landed
    {K_WR, 6'h00, 32'h105, 32'h0,      1'b0, 4'd5},
    {K_RD, 6'h24, 32'h0, 32'h01,       1'b0, 4'd5},
    {K_RD, 6'h00, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd5},  // R5 old value in force
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd5},
    {K_RD, 6'h00, 32'h0, 32'h105,      1'b0, 4'd5},
    {K_RD, 6'h24, 32'h0, 32'h0,        1'b0, 4'd5},
    {K_WR, 6'h1C, 32'h1, 32'h0,        1'b0, 4'd9},
    {K_WR, 6'h20, 32'h1, 32'h0,        1'b0, 4'd2},
    {K_WR, 6'h20, 32'h3, 32'h0,        1'b0, 4'd3},  // R3 snapshot
    {K_RD, 6'h24, 32'h0, 32'h20,       1'b0, 4'd3},
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd3},
    {K_RD, 6'h24, 32'h0, 32'h0,        1'b0, 4'd3},
    {K_RD, 6'h10, 32'h0, 32'h102,      1'b0, 4'd3},
    {K_RD, 6'h20, 32'h0, 32'h1,        1'b0, 4'd3},
    {K_TK, 6'h00, 32'd2, 32'h0,        1'b0, 4'd7},
    {K_RD, 6'h14, 32'h0, 32'h0,        1'b0, 4'd7},  // R7 not yet
    {K_TK, 6'h00, 32'd1, 32'h0,        1'b0, 4'd7},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b1, 4'd9},  // R9 irq up
    {K_WR, 6'h1C, 32'h0, 32'h0,        1'b0, 4'd9},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b0, 4'd9},
    {K_TK, 6'h00, 32'd1, 32'h0,        1'b0, 4'd7},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b0, 4'd7},  // R7 sticky
    {K_WR, 6'h14, 32'h2, 32'h0,        1'b0, 4'd8},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b0, 4'd8},  // R8 zero bit ignored
    {K_WR, 6'h14, 32'hF, 32'h0,        1'b0, 4'd8},
    {K_RD, 6'h14, 32'h0, 32'h0,        1'b0, 4'd8},
    {K_RD, 6'h08, 32'h0, 32'h0,        1'b0, 4'd10}, // R10
    {K_WR, 6'h20, 32'h0, 32'h0,        1'b0, 4'd2},
    {K_TK, 6'h00, 32'd2, 32'h0,        1'b0, 4'd2},
    {K_WR, 6'h20, 32'h2, 32'h0,        1'b0, 4'd2},
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd2},
    {K_RD, 6'h10, 32'h0, 32'h107,      1'b0, 4'd2},  // R2 stopped holds
    {K_WR, 6'h10, 32'hFFFFFFFE, 32'h0, 1'b0, 4'd4},
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd4},
    {K_WR, 6'h00, 32'h1, 32'h0,        1'b0, 4'd5},
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd5},
    {K_WR, 6'h20, 32'h3, 32'h0,        1'b0, 4'd2},
    {K_TK, 6'h00, 32'd3, 32'h0,        1'b0, 4'd2},
    {K_RD, 6'h10, 32'h0, 32'h0,        1'b0, 4'd2},  // R2 wrap
    {K_RD, 6'h14, 32'h0, 32'h0,        1'b0, 4'd7},
    {K_TK, 6'h00, 32'd1, 32'h0,        1'b0, 4'd7},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b0, 4'd7},
    {K_WR, 6'h1C, 32'h1, 32'h0,        1'b0, 4'd9},
    {K_RD, 6'h14, 32'h0, 32'h1,        1'b1, 4'd9},
    {K_WR, 6'h00, 32'h50, 32'h0,       1'b1, 4'd6},
    {K_TK, 6'h00, 32'd2, 32'h0,        1'b1, 4'd6},
    {K_WR, 6'h00, 32'h60, 32'h0,       1'b1, 4'd6},  // R6 restart
    {K_TK, 6'h00, 32'd2, 32'h0,        1'b1, 4'd6},
    {K_RD, 6'h24, 32'h0, 32'h1,        1'b1, 4'd6},
    {K_TK, 6'h00, 32'd1, 32'h0,        1'b1, 4'd6}
  };

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic check_rd(input logic [5:0] a, input logic [31:0] exp_d,
                          input logic exp_irq, input int req);
    @(negedge clk);
    bus_addr = a;
    #1;
    n_run++;
    if (bus_rdata !== exp_d || irq_o !== exp_irq) begin
      n_fail++;
      $display("FAIL R%0d addr %h: rdata %h irq %b, expected %h irq %b",
               req, a, bus_rdata, irq_o, exp_d, exp_irq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][76:75])
        K_WR: bus_wr(VEC[i][74:69], VEC[i][68:37]);
        K_RD: check_rd(VEC[i][74:69], VEC[i][36:5], VEC[i][4], int'(VEC[i][3:0]));
        default: ticks(int'(VEC[i][68:37]));
      endcase
    end
    check_rd(6'h24, 32'h0, 1'b1, 6);   // R6 restarted update landed
    check_rd(6'h00, 32'h60, 1'b1, 6);  // R6 newest value wins

    // R8: a match in the same cycle as a clear keeps the flag
    bus_wr(6'h20, 32'h0);
    bus_wr(6'h00, 32'h10);
    ticks(3);
    bus_wr(6'h10, 32'h0F);
    ticks(3);
    bus_wr(6'h20, 32'h1);
    ticks(1);                          // compares 0x0F, count becomes 0x10
    @(negedge clk);
    bus_addr = 6'h14; bus_wdata = 32'hF; bus_we = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    check_rd(6'h14, 32'h1, 1'b1, 8);   // R8 set wins
    bus_wr(6'h14, 32'hF);
    check_rd(6'h14, 32'h0, 1'b0, 8);   // R8 plain clear
    check_rd(6'h20, 32'h1, 1'b0, 3);   // R3 run bit kept

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_rd(6'h00, 32'hFFFFFFFF, 1'b0, 1);
    check_rd(6'h24, 32'h0, 1'b0, 1);
    check_rd(6'h1C, 32'h0, 1'b0, 1);
    bus_wr(6'h20, 32'h2);
    ticks(3);
    check_rd(6'h10, 32'h0, 1'b0, 1);   // R1 counter zero and stopped

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule